// File: doc/BRIEF.md
# Carrier Detect Qualifier

This block decides whether a receive carrier is present on a half-duplex FSK line. Its input is the digital output of an amplitude comparator, which toggles once per cycle of any received tone that is large enough. The comparator output is synchronised and its rising edges are counted. The flag `cd_o` is raised only after an unbroken run of closely spaced edges. It stays up while each following edge arrives within a hold window. It falls when that window runs out, or as soon as the local side starts transmitting.

With the default settings the hold window is 2.5 ms, which is 1152 cycles of a 460.8 kHz clock, and the run length is four edges. A 1200 Hz tone is therefore recognised in about 3.3 ms and a 2200 Hz tone in about 1.8 ms. The window is derived from the clock rate and a window length in microseconds, or it can be set directly as a number of clocks. Reset is synchronous and active high.

Top module: `carrier_detect_qual`

## Requirements
- R1: While `rts_n` is high, `cd_o` rises only after PULSES_NEEDED (default 4) comparator rising edges in a row, each less than GAP_LIMIT clocks after the one before. With fewer edges, `cd_o` stays low.
- R2: Once `cd_o` is high, it stays high while every further edge comes less than GAP_LIMIT clocks after the previous one. In the cases below, T is the clock on which the last accepted edge was registered.
  - If the next edge comes exactly GAP_LIMIT clocks after T, or later, `cd_o` falls on that edge.
  - If no edge comes at all, `cd_o` falls exactly GAP_LIMIT clocks after T.
- R3: After `cd_o` falls, a complete new run of PULSES_NEEDED edges is needed before it rises again.
- R4: On the clock after `rts_n` is sampled low, `cd_o` is low. While `rts_n` is low, `cd_o` stays low, and any edges that arrive then do not count towards a later run.
- R5: With SYNC_STAGES = 2, `cd_o` rises on the third rising clock edge after the final edge of the run first appears on `cmp_i`.
- R6: While `rst` is high at a clock edge, `cd_o` is low afterwards and the edge count is cleared. The first edge after reset counts as the first edge of a run.
- R7: During acquisition, a gap of GAP_LIMIT clocks or more between edges throws away the partial count. The edge that ends the gap counts as edge one of a new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock (460.8 kHz nominal) |
| rst | input | 1 | Synchronous reset, active high |
| rts_n | input | 1 | Request to send, active low; low means the local side is transmitting |
| cmp_i | input | 1 | Asynchronous output of the amplitude comparator |
| cd_o | output | 1 | Carrier present flag |

## Verification
The bench builds the block with GAP_LIMIT = 40, PULSES_NEEDED = 4 and SYNC_STAGES = 2.

The short window brings both hold boundaries within a few dozen cycles:
- an edge spacing of 39 clocks holds the flag, and a spacing of exactly 40 clocks drops it;
- the silent timeout can be checked on its exact cycle.

Runs that are interrupted by a long gap, by transmit, or by reset are each followed by three edges, which must not raise the flag, and then a fourth edge, which must.

// File: rtl/cdq_pkg.sv
`timescale 1ns/1ps
package cdq_pkg;

    typedef enum logic {
        CD_SEARCH = 1'b0,
        CD_LOCKED = 1'b1
    } cd_state_e;

    // Events handed from the front end to the qualifier FSM
    typedef struct packed {
        logic rise;   // one synchronised rising edge of the comparator
        logic stale;  // hold window has run out since the last edge
    } cdq_evt_t;

    localparam int unsigned DEF_CLK_HZ  = 460800;
    localparam int unsigned DEF_HOLD_US = 2500;
    localparam int unsigned DEF_PULSES  = 4;
    localparam int unsigned DEF_SYNC    = 2;

    // Number of clock cycles in a window given in microseconds
    function automatic int unsigned clocks_in(input longint unsigned hz,
                                              input longint unsigned us);
        longint unsigned prod;
        prod = (hz * us) / 64'd1000000;
        return int'(prod);
    endfunction

endpackage

// File: rtl/cdq_input_sync.sv
`timescale 1ns/1ps
module cdq_input_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cmp_i,
    output logic rise_o
);
    logic [SYNC_STAGES-1:0] stage_q;
    logic [SYNC_STAGES-1:0] stage_d;
    logic                   prev_q;

    generate
        if (SYNC_STAGES == 1) begin : g_single
            assign stage_d = cmp_i;
        end else begin : g_chain
            assign stage_d = {stage_q[SYNC_STAGES-2:0], cmp_i};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            stage_q <= stage_d;
            prev_q  <= stage_q[SYNC_STAGES-1];
        end
    end

    assign rise_o = stage_q[SYNC_STAGES-1] & ~prev_q;

endmodule

// File: rtl/cdq_gap_timer.sv
`timescale 1ns/1ps
module cdq_gap_timer #(
    parameter int unsigned GAP_LIMIT = 1152
) (
    input  logic clk,
    input  logic rst,
    input  logic rise_i,
    output logic stale_o
);
    localparam int unsigned GW = $clog2(GAP_LIMIT + 1);
    localparam logic [GW-1:0] LIMIT = GW'(GAP_LIMIT);

    // Cycles elapsed since the last edge, counting the edge's own cycle;
    // saturates at LIMIT, which also stands for "no recent edge".
    logic [GW-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q <= LIMIT;
        end else if (rise_i) begin
            gap_q <= GW'(1);
        end else if (gap_q < LIMIT) begin
            gap_q <= gap_q + GW'(1);
        end
    end

    assign stale_o = (gap_q >= LIMIT);

endmodule

// File: rtl/cdq_lock_fsm.sv
`timescale 1ns/1ps
module cdq_lock_fsm
    import cdq_pkg::*;
#(
    parameter int unsigned PULSES_NEEDED = 4,
    localparam int unsigned CW = $clog2(PULSES_NEEDED + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rts_n,
    input  cdq_evt_t      evt_i,
    output logic [CW-1:0] cnt_o,
    output logic          cd_o
);
    localparam logic [CW-1:0] LAST = CW'(PULSES_NEEDED - 1);
    localparam logic [CW-1:0] FULL = CW'(PULSES_NEEDED);

    cd_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!rts_n) begin
            state_d = CD_SEARCH;
            cnt_d   = '0;
        end else if (evt_i.stale) begin
            // window lapsed: drop and restart; a late edge opens a new run
            state_d = CD_SEARCH;
            cnt_d   = evt_i.rise ? CW'(1) : '0;
        end else if (evt_i.rise && state_q == CD_SEARCH) begin
            if (cnt_q == LAST) begin
                state_d = CD_LOCKED;
                cnt_d   = FULL;
            end else begin
                cnt_d = cnt_q + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CD_SEARCH;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;
    assign cd_o  = (state_q == CD_LOCKED);

endmodule

// File: rtl/carrier_detect_qual.sv
`timescale 1ns/1ps
module carrier_detect_qual
    import cdq_pkg::*;
#(
    parameter int unsigned CLK_HZ        = DEF_CLK_HZ,
    parameter int unsigned HOLD_US       = DEF_HOLD_US,
    parameter int unsigned GAP_LIMIT     = clocks_in(CLK_HZ, HOLD_US),
    parameter int unsigned PULSES_NEEDED = DEF_PULSES,
    parameter int unsigned SYNC_STAGES   = DEF_SYNC
) (
    input  logic clk,
    input  logic rst,
    input  logic rts_n,
    input  logic cmp_i,
    output logic cd_o
);
    localparam int unsigned CNT_W = $clog2(PULSES_NEEDED + 1);

    logic             rise_w;
    logic             stale_w;
    logic [CNT_W-1:0] pulse_cnt_w;
    cdq_evt_t         evt_w;

    cdq_input_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .cmp_i  (cmp_i),
        .rise_o (rise_w)
    );

    cdq_gap_timer #(.GAP_LIMIT(GAP_LIMIT)) u_gap (
        .clk     (clk),
        .rst     (rst),
        .rise_i  (rise_w),
        .stale_o (stale_w)
    );

    assign evt_w.rise  = rise_w;
    assign evt_w.stale = stale_w;

    cdq_lock_fsm #(.PULSES_NEEDED(PULSES_NEEDED)) u_fsm (
        .clk   (clk),
        .rst   (rst),
        .rts_n (rts_n),
        .evt_i (evt_w),
        .cnt_o (pulse_cnt_w),
        .cd_o  (cd_o)
    );

endmodule

// File: rtl/carrier_detect_qual_chk.sv
`timescale 1ns/1ps
module carrier_detect_qual_chk #(
    parameter int unsigned PULSES_NEEDED = 4,
    parameter int unsigned CW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          rts_n,
    input logic          rise_w,
    input logic          stale_w,
    input logic [CW-1:0] pulse_cnt,
    input logic          cd_o
);
    assert_tx_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        !rts_n |=> !cd_o);

    assert_rise_after_run_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(cd_o) |-> ($past(rise_w) && $past(rts_n) && !$past(stale_w)
                         && $past(pulse_cnt) == CW'(PULSES_NEEDED - 1)));

    assert_cnt_range_R1: assert property (@(posedge clk) disable iff (rst)
        pulse_cnt <= CW'(PULSES_NEEDED));

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (cd_o && rts_n && !stale_w) |=> cd_o);

    assert_drop_cause_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(cd_o) |-> ($past(stale_w) || !$past(rts_n) || $past(rst)));

    assert_stale_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (stale_w && !rise_w) |=> (pulse_cnt == '0));

endmodule

bind carrier_detect_qual carrier_detect_qual_chk #(
    .PULSES_NEEDED(PULSES_NEEDED),
    .CW(CNT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rts_n     (rts_n),
    .rise_w    (rise_w),
    .stale_w   (stale_w),
    .pulse_cnt (pulse_cnt_w),
    .cd_o      (cd_o)
);

// File: tb/carrier_detect_qual_tb.sv
`timescale 1ns/1ps
module carrier_detect_qual_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rts_n = 1'b1;
    logic cmp = 1'b0;
    logic cd;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    carrier_detect_qual #(
        .GAP_LIMIT(40),
        .PULSES_NEEDED(4),
        .SYNC_STAGES(2)
    ) u_dut (
        .clk   (clk),
        .rst   (rst),
        .rts_n (rts_n),
        .cmp_i (cmp),
        .cd_o  (cd)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_cd(input logic exp, input string tag);
        n_chk++;
        if (cd !== exp) begin
            n_bad++;
            $display("FAIL %s: cd_o=%0b expected %0b at %0t", tag, cd, exp, $time);
        end
    endtask

    // one comparator pulse: hi cycles high then lo cycles low (period hi+lo)
    task automatic pulse(input int hi, input int lo);
        cmp = 1'b1;
        step(hi);
        cmp = 1'b0;
        step(lo);
    endtask

    task automatic t_reset;
        rst = 1'b1; rts_n = 1'b1; cmp = 1'b0;
        step(4);
        expect_cd(1'b0, "R6 during reset");
        rst = 1'b0;
        step(2);
        expect_cd(1'b0, "R6 after reset");
    endtask

    task automatic t_acquire;
        repeat (3) pulse(5, 5);
        expect_cd(1'b0, "R1 three edges only");
        cmp = 1'b1;
        step(2);
        expect_cd(1'b0, "R5 two clocks after fourth edge");
        step(1);
        expect_cd(1'b1, "R5 R1 third clock after fourth edge");
        step(2);
        cmp = 1'b0;
        step(5);
    endtask

    task automatic t_hold_boundary;
        for (int i = 0; i < 6; i++) begin
            pulse(10, 29);
            expect_cd(1'b1, "R2 spacing 39 holds");
        end
        pulse(10, 30);
        expect_cd(1'b1, "R2 before spacing-40 edge");
        cmp = 1'b1;
        step(2);
        expect_cd(1'b1, "R2 spacing 40 not yet taken");
        step(1);
        expect_cd(1'b0, "R2 spacing 40 drops");
        step(7);
        cmp = 1'b0;
        step(5);
    endtask

    task automatic t_silence_reacq;
        step(60);
        expect_cd(1'b0, "R3 idle after drop");
        repeat (3) pulse(5, 5);
        expect_cd(1'b0, "R3 three fresh edges");
        cmp = 1'b1;
        step(3);
        expect_cd(1'b1, "R3 fourth fresh edge");
        step(2);
        cmp = 1'b0;
        step(37);
        expect_cd(1'b1, "R2 silence 39 clocks holds");
        step(1);
        expect_cd(1'b0, "R2 silence 40 clocks drops");
    endtask

    task automatic t_gap_acq;
        step(10);
        repeat (2) pulse(5, 5);
        step(50);
        repeat (2) pulse(5, 5);
        expect_cd(1'b0, "R7 gap discards partial run");
        repeat (2) pulse(5, 5);
        expect_cd(1'b1, "R7 new run of four locks");
    endtask

    task automatic t_tx_inhibit;
        rts_n = 1'b0;
        step(1);
        expect_cd(1'b0, "R4 transmit clears flag");
        for (int i = 0; i < 6; i++) begin
            pulse(5, 5);
            expect_cd(1'b0, "R4 edges ignored during transmit");
        end
        rts_n = 1'b1;
        repeat (3) pulse(5, 5);
        expect_cd(1'b0, "R4 transmit edges not counted");
        pulse(5, 5);
        expect_cd(1'b1, "R4 relock after transmit");
    endtask

    task automatic t_reset_midlock;
        rst = 1'b1;
        step(1);
        expect_cd(1'b0, "R6 reset while locked");
        step(2);
        rst = 1'b0;
        repeat (3) pulse(5, 5);
        expect_cd(1'b0, "R6 count cleared by reset");
        pulse(5, 5);
        expect_cd(1'b1, "R6 relock after reset");
    endtask

    initial begin
        t_reset();
        t_acquire();
        t_hold_boundary();
        t_silence_reacq();
        t_gap_acq();
        t_tx_inhibit();
        t_reset_midlock();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule